// File: doc/BRIEF.md
# Nested Prioritised Interrupt Controller

This block arbitrates a set of interrupt request lines plus one non-maskable line on behalf of a processor core. Each request line has an enable flag, a pending flag, an active flag and an 8-bit urgency level. Software reaches these through a small word-wide register port. Whenever a pending, enabled line is strictly more urgent than the level the core is running at, the block raises a take request that carries the winning line number.

Once the core acknowledges, the block marks the line active, pushes the interrupted context's level and line onto a nesting stack, and models entry stacking as a fixed busy window. It then pulses a handler-start strobe. A preempted handler keeps its active flag while it waits on the stack. On a return, if another pending line beats the level being restored, the block chains straight into that handler without a busy window. If a more urgent line shows up during the busy window, it replaces the original target, and the original becomes pending again.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Register address 0 sets enable flags and address 1 clears them, one data bit per line, 1 acting and 0 ignored. Reading either address returns the enable flags in bits N_IRQ-1:0.
- R2: A rising edge on a request line sets its pending flag whether the line is enabled or not. Writing ones to address 2 sets pending flags and writing ones to address 3 clears them. Reading address 2 or 3 returns the pending flags. A clear written in the same cycle as an edge on that line wins.
- R3: take_req is high only when a line is both pending and enabled, its level plus one is strictly below exec_prio, and no stacking window is open. A lower level value means more urgency. Among equal levels the lower line number is offered in take_id.
- R4: When take_ack is sampled high while take_req is high, in that same edge the line's pending flag clears, its active flag sets and exec_prio becomes its level plus one. stacking is then high for exactly STACK_CYC cycles with take_req low. After that, hdl_start pulses for one cycle with hdl_id and with hdl_chain low.
- R5: A preempted handler keeps its active flag. A return (ret_req) with nothing eligible clears the active flag of the running handler and restores exec_prio to the stacked level, or to all ones when the stack is empty.
- R6: Address 4 reads the active flags, and writes to it have no effect.
- R7: On a return, if a pending enabled line is strictly more urgent than the level being restored, the controller enters it directly. It pulses hdl_start with hdl_chain high in the next cycle, opens no stacking window, and exec_prio becomes that line's level plus one.
- R8: If a line more urgent than the current target becomes eligible while stacking is high, it replaces the target without restarting the window. The old target becomes pending and inactive again, and it is served later by chaining.
- R9: A rising edge on nmi_in makes a non-maskable request with line number N_IRQ and exec level 0. This request beats every other line and ignores the enable flags.
- R10: The address with bit ADDR_W-1 set and low bits i reads and writes the 8-bit level of line i (8+i with the defaults).
- R11: After reset all flags and levels are zero, exec_prio is all ones, and take_req, stacking and hdl_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Request lines, edge sensitive |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| take_req | output | 1 | An eligible line can preempt |
| take_id | output | IDW | Line offered for entry |
| take_ack | input | 1 | Core accepts the offered line |
| ret_req | input | 1 | Running handler returns |
| stacking | output | 1 | Entry stacking window open |
| hdl_start | output | 1 | Handler starts this cycle |
| hdl_id | output | IDW | Line whose handler starts |
| hdl_chain | output | 1 | The start was a direct chain |
| exec_prio | output | PRIO_W+1 | Current execution level |

## Verification
The properties assume the core plays fair. It raises take_ack only while take_req is high and never in the same cycle as ret_req. It asserts ret_req only after a handler has started and outside the stacking window. The bench drives these strobes through one task per handshake, each holding the strobe for a single cycle at a falling edge, and it waits for the hdl_start pulse before it issues any return. Request lines and register writes change only on falling edges, and the bench never writes to two flag addresses in the same cycle.

// File: rtl/inc_pkg.sv
package inc_pkg;
  typedef enum logic [2:0] {
    OP_EN_SET = 3'd0,
    OP_EN_CLR = 3'd1,
    OP_PD_SET = 3'd2,
    OP_PD_CLR = 3'd3,
    OP_ACT_RD = 3'd4
  } reg_op_e;
endpackage

// File: rtl/inc_line_bank.sv
module inc_line_bank #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        irq_in,
  input  logic [N_IRQ-1:0]        en_set,
  input  logic [N_IRQ-1:0]        en_clr,
  input  logic [N_IRQ-1:0]        pd_set,
  input  logic [N_IRQ-1:0]        pd_clr,
  input  logic [N_IRQ-1:0]        prio_we,
  input  logic [PRIO_W-1:0]       prio_wdata,
  input  logic [N_IRQ-1:0]        take_oh,
  input  logic [N_IRQ-1:0]        drop_oh,
  input  logic [N_IRQ-1:0]        repend_oh,
  output logic [N_IRQ-1:0]        en_q,
  output logic [N_IRQ-1:0]        pend_q,
  output logic [N_IRQ-1:0]        act_q,
  output logic [N_IRQ*PRIO_W-1:0] prio_flat
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic              irq_d, en_r, pd_r, act_r;
    logic              en_n, pd_n, act_n, rise;
    logic [PRIO_W-1:0] pr_r, pr_n;

    always_comb begin
      rise  = irq_in[g] & ~irq_d;
      en_n  = en_r;
      if (en_set[g])      en_n = 1'b1;
      else if (en_clr[g]) en_n = 1'b0;
      pd_n  = pd_r;
      if (take_oh[g])                         pd_n = 1'b0;
      if (repend_oh[g] || rise || pd_set[g])  pd_n = 1'b1;
      if (pd_clr[g])                          pd_n = 1'b0;
      act_n = act_r;
      if (drop_oh[g] || repend_oh[g]) act_n = 1'b0;
      if (take_oh[g])                 act_n = 1'b1;
      pr_n  = prio_we[g] ? prio_wdata : pr_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_d <= 1'b0;
        en_r  <= 1'b0;
        pd_r  <= 1'b0;
        act_r <= 1'b0;
        pr_r  <= '0;
      end else begin
        irq_d <= irq_in[g];
        en_r  <= en_n;
        pd_r  <= pd_n;
        act_r <= act_n;
        pr_r  <= pr_n;
      end
    end

    assign en_q[g]                     = en_r;
    assign pend_q[g]                   = pd_r;
    assign act_q[g]                    = act_r;
    assign prio_flat[g*PRIO_W +: PRIO_W] = pr_r;
  end
endmodule

// File: rtl/inc_arbiter.sv
module inc_arbiter #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 8,
  parameter int IDW    = 4,
  parameter int EW     = PRIO_W + 1
) (
  input  logic [N_IRQ-1:0]        cand,
  input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
  input  logic                    nmi_cand,
  output logic                    win_valid,
  output logic [IDW-1:0]          win_id,
  output logic [EW-1:0]           win_eff
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_eff   = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && (!win_valid ||
          ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} + EW'(1)) < win_eff)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_eff   = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]} + EW'(1);
      end
    end
    if (nmi_cand) begin
      win_valid = 1'b1;
      win_id    = IDW'(N_IRQ);
      win_eff   = '0;
    end
  end
endmodule

// File: rtl/inc_nest_stack.sv
module inc_nest_stack #(
  parameter int DEPTH = 9,
  parameter int EW    = 9,
  parameter int IDW   = 4,
  parameter int THR_ID = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [EW-1:0]              push_exec,
  input  logic [IDW-1:0]             push_id,
  output logic [EW-1:0]              top_exec,
  output logic [IDW-1:0]             top_id,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int SPW = $clog2(DEPTH+1);

  logic [EW-1:0]  exec_mem [DEPTH];
  logic [IDW-1:0] id_mem   [DEPTH];
  logic [SPW-1:0] sp_r, sp_n;

  always_comb begin
    sp_n = sp_r;
    if (push && sp_r < SPW'(DEPTH)) sp_n = sp_r + SPW'(1);
    else if (pop && sp_r != '0)     sp_n = sp_r - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_r <= '0;
    else        sp_r <= sp_n;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && sp_r == SPW'(i)) begin
        exec_mem[i] <= push_exec;
        id_mem[i]   <= push_id;
      end
    end
  end

  always_comb begin
    top_exec = '1;
    top_id   = IDW'(THR_ID);
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_r == SPW'(i + 1)) begin
        top_exec = exec_mem[i];
        top_id   = id_mem[i];
      end
    end
  end

  assign depth = sp_r;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_W    = 8,
  parameter int STACK_CYC = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(N_IRQ),
  localparam int SEL_W    = (IDX_W > 3) ? IDX_W : 3,
  localparam int ADDR_W   = SEL_W + 1,
  localparam int IDW      = $clog2(N_IRQ + 2),
  localparam int EW       = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              nmi_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              take_req,
  output logic [IDW-1:0]    take_id,
  input  logic              take_ack,
  input  logic              ret_req,
  output logic              stacking,
  output logic              hdl_start,
  output logic [IDW-1:0]    hdl_id,
  output logic              hdl_chain,
  output logic [EW-1:0]     exec_prio
);
  import inc_pkg::*;

  localparam int DEPTH  = N_IRQ + 1;
  localparam int SPW    = $clog2(DEPTH + 1);
  localparam int CW     = $clog2(STACK_CYC + 1);
  localparam int NMI_ID = N_IRQ;
  localparam int THR_ID = N_IRQ + 1;

  // register port decode
  logic              ctrl_sel;
  reg_op_e           op;
  logic [N_IRQ-1:0]  en_set, en_clr, pd_set, pd_clr, prio_we;
  logic [N_IRQ-1:0]  line_en, line_pend, line_act;
  logic [N_IRQ*PRIO_W-1:0] prio_flat;

  always_comb begin
    ctrl_sel = ~reg_addr[ADDR_W-1];
    op       = reg_op_e'(reg_addr[2:0]);
    en_set   = '0;
    en_clr   = '0;
    pd_set   = '0;
    pd_clr   = '0;
    if (reg_wr && ctrl_sel) begin
      case (op)
        OP_EN_SET: en_set = reg_wdata[N_IRQ-1:0];
        OP_EN_CLR: en_clr = reg_wdata[N_IRQ-1:0];
        OP_PD_SET: pd_set = reg_wdata[N_IRQ-1:0];
        OP_PD_CLR: pd_clr = reg_wdata[N_IRQ-1:0];
        default:   ;
      endcase
    end
    for (int i = 0; i < N_IRQ; i++)
      prio_we[i] = reg_wr && !ctrl_sel && (reg_addr[SEL_W-1:0] == SEL_W'(i));
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel) begin
      case (op)
        OP_EN_SET, OP_EN_CLR: reg_rdata[N_IRQ-1:0] = line_en;
        OP_PD_SET, OP_PD_CLR: reg_rdata[N_IRQ-1:0] = line_pend;
        OP_ACT_RD:            reg_rdata[N_IRQ-1:0] = line_act;
        default:              ;
      endcase
    end else begin
      for (int i = 0; i < N_IRQ; i++)
        if (reg_addr[SEL_W-1:0] == SEL_W'(i))
          reg_rdata[PRIO_W-1:0] = prio_flat[i*PRIO_W +: PRIO_W];
    end
  end

  // control state
  logic [CW-1:0]  cnt_r, cnt_n;
  logic [EW-1:0]  cur_exec_r, cur_exec_n;
  logic [IDW-1:0] cur_id_r, cur_id_n;
  logic           nmi_d, nmi_pend_r, nmi_pend_n, nmi_act_r, nmi_act_n;
  logic           hs_r, hs_n, hch_r, hch_n;
  logic [IDW-1:0] hid_r;

  logic           win_valid;
  logic [IDW-1:0] win_id;
  logic [EW-1:0]  win_eff;
  logic [EW-1:0]  top_exec;
  logic [IDW-1:0] top_id;
  logic [SPW-1:0] depth;

  logic busy, ack, late, ret, chain, take_any, push, pop, nmi_rise;
  logic [N_IRQ-1:0] take_oh, drop_oh, repend_oh;

  always_comb begin
    busy     = (cnt_r != '0);
    take_req = win_valid && (win_eff < cur_exec_r) && !busy;
    ack      = take_req && take_ack && !ret_req;
    late     = busy && win_valid && (win_eff < cur_exec_r);
    ret      = ret_req && !busy && (depth != '0);
    chain    = ret && win_valid && (win_eff < top_exec);
    take_any = ack || late || chain;
    push     = ack;
    pop      = ret && !chain;
    nmi_rise = nmi_in && !nmi_d;

    for (int i = 0; i < N_IRQ; i++) begin
      take_oh[i]   = take_any && (win_id == IDW'(i));
      drop_oh[i]   = ret && (cur_id_r == IDW'(i));
      repend_oh[i] = late && (cur_id_r == IDW'(i));
    end

    nmi_pend_n = nmi_pend_r;
    if (take_any && win_id == IDW'(NMI_ID))                 nmi_pend_n = 1'b0;
    if (nmi_rise || (late && cur_id_r == IDW'(NMI_ID)))     nmi_pend_n = 1'b1;
    nmi_act_n = nmi_act_r;
    if ((ret || late) && cur_id_r == IDW'(NMI_ID))          nmi_act_n = 1'b0;
    if (take_any && win_id == IDW'(NMI_ID))                 nmi_act_n = 1'b1;

    cur_exec_n = cur_exec_r;
    cur_id_n   = cur_id_r;
    if (take_any) begin
      cur_exec_n = win_eff;
      cur_id_n   = win_id;
    end else if (pop) begin
      cur_exec_n = top_exec;
      cur_id_n   = top_id;
    end

    cnt_n = cnt_r;
    if (ack)       cnt_n = CW'(STACK_CYC);
    else if (busy) cnt_n = cnt_r - CW'(1);

    hs_n  = (busy && cnt_r == CW'(1)) || chain;
    hch_n = chain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r      <= '0;
      cur_exec_r <= '1;
      cur_id_r   <= IDW'(THR_ID);
      nmi_d      <= 1'b0;
      nmi_pend_r <= 1'b0;
      nmi_act_r  <= 1'b0;
      hs_r       <= 1'b0;
      hch_r      <= 1'b0;
      hid_r      <= '0;
    end else begin
      cnt_r      <= cnt_n;
      cur_exec_r <= cur_exec_n;
      cur_id_r   <= cur_id_n;
      nmi_d      <= nmi_in;
      nmi_pend_r <= nmi_pend_n;
      nmi_act_r  <= nmi_act_n;
      hs_r       <= hs_n;
      hch_r      <= hch_n;
      if (hs_n) hid_r <= cur_id_n;
    end
  end

  inc_line_bank #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
    .prio_we(prio_we), .prio_wdata(reg_wdata[PRIO_W-1:0]),
    .take_oh(take_oh), .drop_oh(drop_oh), .repend_oh(repend_oh),
    .en_q(line_en), .pend_q(line_pend), .act_q(line_act), .prio_flat(prio_flat)
  );

  inc_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDW(IDW), .EW(EW)) u_arb (
    .cand(line_pend & line_en), .prio_flat(prio_flat), .nmi_cand(nmi_pend_r),
    .win_valid(win_valid), .win_id(win_id), .win_eff(win_eff)
  );

  inc_nest_stack #(.DEPTH(DEPTH), .EW(EW), .IDW(IDW), .THR_ID(THR_ID)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_exec(cur_exec_r), .push_id(cur_id_r),
    .top_exec(top_exec), .top_id(top_id), .depth(depth)
  );

  assign take_id   = win_id;
  assign stacking  = busy;
  assign hdl_start = hs_r;
  assign hdl_chain = hch_r;
  assign hdl_id    = hid_r;
  assign exec_prio = cur_exec_r;
endmodule

// File: rtl/inc_checker.sv
module inc_checker #(
  parameter int N_IRQ = 8,
  parameter int IDW   = 4,
  parameter int EW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take_req,
  input logic [IDW-1:0]   take_id,
  input logic             take_ack,
  input logic             ret_req,
  input logic             stacking,
  input logic             hdl_start,
  input logic             hdl_chain,
  input logic [EW-1:0]    exec_prio,
  input logic [N_IRQ-1:0] act_vec,
  input logic [N_IRQ-1:0] en_vec,
  input logic             nmi_pend
);
  // R4: no offer while the stacking window is open
  a_r4_quiet_while_stacking: assert property (@(posedge clk) disable iff (!rst_n)
    stacking |-> !take_req);

  // R4: accepted line is active in the following cycle
  a_r4_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && take_ack && !ret_req && take_id < IDW'(N_IRQ))
      |=> |(act_vec & (N_IRQ'(1) << $past(take_id))));

  // R4: entry raises urgency
  a_r4_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && take_ack && !ret_req) |=> exec_prio < $past(exec_prio));

  // R3: a maskable offer must be enabled
  a_r3_offer_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && take_id < IDW'(N_IRQ)) |-> |(en_vec & (N_IRQ'(1) << take_id)));

  // R7: a start follows either a window or a return
  a_r7_start_source: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_start |-> ($past(stacking) || $past(ret_req)));

  // R7: a chained start never overlaps a window
  a_r7_chain_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_chain |-> (hdl_start && !stacking));

  // R9: a waiting non-maskable request is offered first
  a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !stacking && exec_prio != '0) |-> (take_req && take_id == IDW'(N_IRQ)));
endmodule

bind irq_nest_ctrl inc_checker #(.N_IRQ(N_IRQ), .IDW(IDW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_id(take_id),
  .take_ack(take_ack), .ret_req(ret_req), .stacking(stacking),
  .hdl_start(hdl_start), .hdl_chain(hdl_chain), .exec_prio(exec_prio),
  .act_vec(line_act), .en_vec(line_en), .nmi_pend(nmi_pend_r)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
  localparam int N = 8, PW = 8, SC = 4, DW = 32, AW = 4, IDW = 4, EW = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          nmi_in, reg_wr, take_ack, ret_req;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          take_req, stacking, hdl_start, hdl_chain;
  logic [IDW-1:0] take_id, hdl_id;
  logic [EW-1:0] exec_prio;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  irq_nest_ctrl #(.N_IRQ(N), .PRIO_W(PW), .STACK_CYC(SC), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .take_req(take_req), .take_id(take_id), .take_ack(take_ack), .ret_req(ret_req),
    .stacking(stacking), .hdl_start(hdl_start), .hdl_id(hdl_id),
    .hdl_chain(hdl_chain), .exec_prio(exec_prio)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_irq(input int idx);
    @(negedge clk); irq_in[idx] = 1'b1;
    @(negedge clk); irq_in[idx] = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); take_ack = 1'b1;
    @(negedge clk); take_ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
  endtask

  task automatic wait_start(output int cyc);
    cyc = 0;
    while (!hdl_start && cyc < 50) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R11 take_req", take_req, 0);
    check("R11 exec_prio", exec_prio, 9'h1FF);
    check("R11 stacking", stacking, 0);
    check("R11 hdl_start", hdl_start, 0);
    rd(0, d); check("R11 enables", d, 0);
    rd(2, d); check("R11 pending", d, 0);
    rd(4, d); check("R11 active", d, 0);
    rd(8 + 5, d); check("R11 level", d, 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] d;
    wr(0, 32'h0F); rd(0, d); check("R1 set", d, 32'h0F);
    wr(1, 32'h05); rd(1, d); check("R1 clear", d, 32'h0A);
    wr(1, 32'hFF); rd(0, d); check("R1 clear all", d, 0);
  endtask

  task automatic t_prio();
    logic [DW-1:0] d;
    wr(8 + 3, 32'h5A); rd(8 + 3, d); check("R10 level 3", d, 32'h5A);
    rd(8 + 2, d); check("R10 level 2 untouched", d, 0);
  endtask

  task automatic t_pending();
    logic [DW-1:0] d;
    pulse_irq(2);
    rd(2, d); check("R2 edge on disabled line", d, 32'h04);
    check("R3 disabled line not offered", take_req, 0);
    wr(2, 32'h20); rd(3, d); check("R2 software set", d, 32'h24);
    wr(3, 32'h24); rd(2, d); check("R2 software clear", d, 0);
    @(negedge clk); irq_in[4] = 1'b1; reg_wr = 1'b1; reg_addr = 3; reg_wdata = 32'h10;
    @(negedge clk); reg_wr = 1'b0; irq_in[4] = 1'b0;
    rd(2, d); check("R2 clear beats edge", d, 0);
  endtask

  task automatic t_arb_chain();
    logic [DW-1:0] d;
    int cyc;
    wr(0, 32'hFF);
    wr(8 + 1, 32'h40); wr(8 + 6, 32'h20); wr(8 + 2, 32'h20);
    wr(2, 32'h46);
    check("R3 take_req", take_req, 1);
    check("R3 tie lower number", take_id, 2);
    do_ack();
    rd(4, d); check("R4 active set", d, 32'h04);
    rd(2, d); check("R4 pending cleared", d, 32'h42);
    check("R4 exec level", exec_prio, 9'h021);
    check("R4 stacking", stacking, 1);
    check("R4 no offer in window", take_req, 0);
    wait_start(cyc);
    check("R4 window length", cyc, SC);
    check("R4 start id", hdl_id, 2);
    check("R4 not chained", hdl_chain, 0);
    @(negedge clk);
    check("R3 equal level no preempt", take_req, 0);
    do_ret();
    check("R7 chain start", hdl_start, 1);
    check("R7 chain flag", hdl_chain, 1);
    check("R7 chain id", hdl_id, 6);
    check("R7 no window", stacking, 0);
    check("R7 exec level", exec_prio, 9'h021);
    rd(4, d); check("R7 active", d, 32'h40);
    do_ret();
    check("R7 second chain id", hdl_id, 1);
    check("R7 second exec", exec_prio, 9'h041);
    do_ret();
    check("R5 back to thread", exec_prio, 9'h1FF);
    check("R5 no start", hdl_start, 0);
    rd(4, d); check("R5 active clear", d, 0);
  endtask

  task automatic t_nest();
    logic [DW-1:0] d;
    int cyc;
    wr(8 + 0, 32'h80); wr(8 + 7, 32'h10);
    pulse_irq(0);
    do_ack(); wait_start(cyc);
    check("R5 outer exec", exec_prio, 9'h081);
    wr(4, 32'h00); rd(4, d); check("R6 write ignored", d, 32'h01);
    pulse_irq(7);
    check("R3 preempt offer", take_id, 7);
    do_ack(); wait_start(cyc);
    check("R5 inner exec", exec_prio, 9'h011);
    rd(4, d); check("R5 active stacked", d, 32'h81);
    do_ret();
    check("R5 restored level", exec_prio, 9'h081);
    rd(4, d); check("R5 inner cleared", d, 32'h01);
    do_ret();
    check("R5 thread level", exec_prio, 9'h1FF);
    wr(4, 32'hFF); rd(4, d); check("R6 idle write ignored", d, 0);
  endtask

  task automatic t_late();
    logic [DW-1:0] d;
    int cyc;
    wr(8 + 3, 32'h60); wr(8 + 5, 32'h08);
    pulse_irq(3);
    do_ack();
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk);
    rd(4, d); check("R8 new target active", d, 32'h20);
    rd(2, d); check("R8 old target pending", d, 32'h08);
    check("R8 exec level", exec_prio, 9'h009);
    wait_start(cyc);
    check("R8 window not restarted", cyc + 3, SC);
    check("R8 start id", hdl_id, 5);
    do_ret();
    check("R8 chained to old target", hdl_id, 3);
    check("R8 chain flag", hdl_chain, 1);
    do_ret();
    check("R8 thread", exec_prio, 9'h1FF);
  endtask

  task automatic t_nmi();
    logic [DW-1:0] d;
    int cyc;
    wr(8 + 4, 32'h00);
    pulse_irq(4);
    do_ack(); wait_start(cyc);
    check("R9 line 4 exec", exec_prio, 9'h001);
    wr(1, 32'hFF);
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    check("R9 offer", take_req, 1);
    check("R9 id", take_id, N);
    do_ack(); wait_start(cyc);
    check("R9 start id", hdl_id, N);
    check("R9 exec zero", exec_prio, 0);
    rd(4, d); check("R9 line 4 stacked", d, 32'h10);
    do_ret();
    check("R9 restored", exec_prio, 9'h001);
    do_ret();
    check("R9 thread", exec_prio, 9'h1FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; nmi_in = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; take_ack = 1'b0; ret_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_prio();
    t_pending();
    t_arb_chain();
    t_nest();
    t_late();
    t_nmi();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule